// File: doc/BRIEF.md
# Phase-Leg Interlock and Fault Shutdown Controller

This block is the low-voltage control logic of a seven-output power-stage gate driver. A microcontroller sends it one upper and one lower switch request for each of several phase legs, plus one extra lower-side request. The extra request serves a brake chopper or a power-factor stage. The block returns a gate-enable command for every power switch. All requests and status inputs cross into the block's clock domain through multi-flop synchronizers. After that, a single register stage produces the gate commands.

Each phase leg has a hardware cross-conduction guard that can be switched on or off. When the guard is on, a lower request takes priority over an upper request in the same leg. The extra channel never takes part in this guard. An undervoltage lockout input turns every gate off for as long as it is present.

Two fault inputs come from external comparators that have already been digitized: shunt over-current and over-temperature. Either one latches a per-source error flag, pulls a registered active-low global error line low and turns every gate off. Only a clear pulse given after both fault inputs have gone quiet releases the latch.

Top module: `gdrv_ctrl`

## Requirements
- R1: With no fault and no lockout, each gate output copies its synchronized request; an input change appears at the output exactly SYNC_STAGES+1 clock edges later (3 with defaults).
- R2: With the guard on (`ilock_en`=1), a leg whose lower request is active has its upper gate at 0 and its lower gate at 1, whatever the upper request is.
- R3: While the guard is on, the upper and lower gates of the same leg are never 1 together.
- R4: With the guard off (`ilock_en`=0), both gates of a leg follow their own requests, including both at 1.
- R5: `aux_gate` follows `aux_req` and is not affected by the guard setting or by any leg request.
- R6: While `uvlo` is 1, every gate output is 0; when lockout ends with no fault latched, the gates follow their requests again.
- R7: Lockout on its own sets no error flag and leaves `err_n` at 1.
- R8: An over-current input sets `flt_local` bit 0 and an over-temperature input sets bit 1. On the edge where a flag sets, `err_n` goes to 0 and every gate goes to 0.
- R9: A set flag, together with `err_n`=0 and all gates off, stays in place after the fault inputs return to 0, until a `flt_clr` pulse arrives.
- R10: A `flt_clr` pulse given while either fault input is still 1 clears nothing.
- R11: The end of an undervoltage lockout does not clear a latched fault.
- R12: During and right after reset, all gates are 0, `flt_local` is 0 and `err_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_req | input | NUM_PAIRS | Upper-switch requests, one per leg |
| lo_req | input | NUM_PAIRS | Lower-switch requests, one per leg |
| aux_req | input | 1 | Extra lower-side channel request |
| ilock_en | input | 1 | 1 turns on the per-leg cross-conduction guard |
| uvlo | input | 1 | 1 while supply is below the lockout level |
| oc_trip | input | 1 | Digitized shunt over-current comparator |
| ot_trip | input | 1 | Digitized over-temperature comparator |
| flt_clr | input | 1 | Fault release pulse |
| hi_gate | output | NUM_PAIRS | Upper gate commands |
| lo_gate | output | NUM_PAIRS | Lower gate commands |
| aux_gate | output | 1 | Extra channel gate command |
| flt_local | output | 2 | Latched error flags: bit 0 over-current, bit 1 over-temperature |
| err_n | output | 1 | Registered active-low global error |

## Verification
The checker watches the synchronized copies of the guard select, lockout, clear and fault signals. It therefore assumes that every input is either asynchronous to the clock or held stable long enough that the synchronizer samples one clean level. The bench drives inputs only on the falling edge and holds each level for several cycles, so every change is seen as one synchronized step. Clear pulses last exactly one clock cycle. Fault inputs are held until the outputs have settled, so each flag assertion can be traced back to a fault input that was present at the synchronizer output.

// File: rtl/gdrv_pkg.sv
package gdrv_pkg;
   localparam int FLT_OC  = 0;
   localparam int FLT_OT  = 1;
   localparam int NUM_FLT = 2;
   typedef logic [NUM_FLT-1:0] flt_vec_t;
endpackage

// File: rtl/gdrv_sync.sv
module gdrv_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   localparam int CW = W * STAGES;

   if (STAGES < 2) begin : g_bad_stages
      $error("gdrv_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("gdrv_sync: W must be at least 1");
   end

   logic [CW-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[CW-W-1:0], d};
   end

   assign q = chain[CW-1 -: W];
endmodule

// File: rtl/gdrv_pair.sv
module gdrv_pair (
   input  logic lock,
   input  logic hi_in,
   input  logic lo_in,
   output logic hi_cmd,
   output logic lo_cmd
);
   // lower request takes priority within the leg when guarded
   always_comb begin
      lo_cmd = lo_in;
      hi_cmd = hi_in & ~(lock & lo_in);
   end
endmodule

// File: rtl/gdrv_fault.sv
module gdrv_fault
   import gdrv_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  flt_vec_t cond,
   input  logic     clr,
   output logic     trip,
   output flt_vec_t flags,
   output logic     err_n
);
   flt_vec_t flags_nxt;
   logic     any_cond;

   always_comb begin
      any_cond  = |cond;
      flags_nxt = flags | cond;
      if (clr && !any_cond) flags_nxt = '0;
      trip = |flags_nxt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags <= '0;
         err_n <= 1'b1;
      end else begin
         flags <= flags_nxt;
         err_n <= ~(|flags_nxt);
      end
   end
endmodule

// File: rtl/gdrv_ctrl.sv
module gdrv_ctrl
   import gdrv_pkg::*;
#(
   parameter int NUM_PAIRS     = 3,
   parameter int SYNC_STAGES   = 2,
   parameter bit ILOCK_PIN_SEL = 1'b1,
   parameter bit HAS_AUX       = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_PAIRS-1:0] hi_req,
   input  logic [NUM_PAIRS-1:0] lo_req,
   input  logic                 aux_req,
   input  logic                 ilock_en,
   input  logic                 uvlo,
   input  logic                 oc_trip,
   input  logic                 ot_trip,
   input  logic                 flt_clr,
   output logic [NUM_PAIRS-1:0] hi_gate,
   output logic [NUM_PAIRS-1:0] lo_gate,
   output logic                 aux_gate,
   output logic [1:0]           flt_local,
   output logic                 err_n
);
   localparam int IW      = 2 * NUM_PAIRS + 6;
   localparam int IX_LO   = NUM_PAIRS;
   localparam int IX_AUX  = 2 * NUM_PAIRS;
   localparam int IX_LOCK = IX_AUX + 1;
   localparam int IX_UV   = IX_AUX + 2;
   localparam int IX_OC   = IX_AUX + 3;
   localparam int IX_OT   = IX_AUX + 4;
   localparam int IX_CLR  = IX_AUX + 5;

   if (NUM_PAIRS < 1) begin : g_bad_pairs
      $error("gdrv_ctrl: NUM_PAIRS must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gdrv_ctrl: SYNC_STAGES must be at least 2");
   end
   if (NUM_FLT != 2) begin : g_bad_flt
      $error("gdrv_ctrl: flag port sized for two fault sources");
   end

   logic [IW-1:0]        raw_in;
   logic [IW-1:0]        syn;
   logic [NUM_PAIRS-1:0] hi_s;
   logic [NUM_PAIRS-1:0] lo_s;
   logic                 aux_s;
   logic                 ilock_s;
   logic                 uv_s;
   logic                 clr_s;
   flt_vec_t             cond_s;
   logic                 lock_eff;
   logic [NUM_PAIRS-1:0] hi_cmd;
   logic [NUM_PAIRS-1:0] lo_cmd;
   logic                 trip;
   logic                 kill;
   flt_vec_t             flags;

   assign raw_in = {flt_clr, ot_trip, oc_trip, uvlo, ilock_en, aux_req, lo_req, hi_req};

   gdrv_sync #(.W(IW), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (syn)
   );

   assign hi_s    = syn[IX_LO-1:0];
   assign lo_s    = syn[IX_AUX-1:IX_LO];
   assign aux_s   = syn[IX_AUX];
   assign ilock_s = syn[IX_LOCK];
   assign uv_s    = syn[IX_UV];
   assign clr_s   = syn[IX_CLR];

   always_comb begin
      cond_s         = '0;
      cond_s[FLT_OC] = syn[IX_OC];
      cond_s[FLT_OT] = syn[IX_OT];
   end

   if (ILOCK_PIN_SEL) begin : g_lock_pin
      assign lock_eff = ilock_s;
   end else begin : g_lock_fixed
      assign lock_eff = 1'b1;
   end

   for (genvar gp = 0; gp < NUM_PAIRS; gp++) begin : g_leg
      gdrv_pair u_pair (
         .lock   (lock_eff),
         .hi_in  (hi_s[gp]),
         .lo_in  (lo_s[gp]),
         .hi_cmd (hi_cmd[gp]),
         .lo_cmd (lo_cmd[gp])
      );
   end

   gdrv_fault u_flt (
      .clk   (clk),
      .rst_n (rst_n),
      .cond  (cond_s),
      .clr   (clr_s),
      .trip  (trip),
      .flags (flags),
      .err_n (err_n)
   );

   assign flt_local = flags;
   assign kill      = trip | uv_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_gate <= '0;
         lo_gate <= '0;
      end else if (kill) begin
         hi_gate <= '0;
         lo_gate <= '0;
      end else begin
         hi_gate <= hi_cmd;
         lo_gate <= lo_cmd;
      end
   end

   if (HAS_AUX) begin : g_aux
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) aux_gate <= 1'b0;
         else        aux_gate <= aux_s & ~kill;
      end
   end else begin : g_no_aux
      assign aux_gate = 1'b0;
   end
endmodule

// File: rtl/gdrv_ctrl_chk.sv
module gdrv_ctrl_chk
   import gdrv_pkg::*;
#(
   parameter int NUM_PAIRS = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_PAIRS-1:0] hi_gate,
   input logic [NUM_PAIRS-1:0] lo_gate,
   input logic                 aux_gate,
   input logic [1:0]           flt_local,
   input logic                 err_n,
   input logic                 lock_eff,
   input logic                 uv_s,
   input logic                 clr_s,
   input flt_vec_t             cond_s
);
   AST_ILOCK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $past(lock_eff) |-> ((hi_gate & lo_gate) == '0)); // R3

   AST_UV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      $past(uv_s) |-> (hi_gate == '0 && lo_gate == '0 && !aux_gate)); // R6

   AST_ERR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !err_n |-> (hi_gate == '0 && lo_gate == '0 && !aux_gate)); // R8

   AST_ERR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      err_n == (flt_local == 2'b00)); // R8

   AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_local & ~$past(flt_local) & ~$past(cond_s)) == 2'b00); // R7

   AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(flt_local) & ~flt_local) != 2'b00) |-> $past(clr_s)); // R9

   AST_CLR_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(flt_local) & ~flt_local) != 2'b00) |-> ($past(cond_s) == 2'b00)); // R10
endmodule

bind gdrv_ctrl gdrv_ctrl_chk #(.NUM_PAIRS(NUM_PAIRS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .hi_gate   (hi_gate),
   .lo_gate   (lo_gate),
   .aux_gate  (aux_gate),
   .flt_local (flt_local),
   .err_n     (err_n),
   .lock_eff  (lock_eff),
   .uv_s      (uv_s),
   .clr_s     (clr_s),
   .cond_s    (cond_s)
);

// File: tb/tb_gdrv_ctrl.sv
module tb_gdrv_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int NP         = 3;
   localparam int SYNC       = 2;
   localparam int LAT        = SYNC + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] hi_req = '0;
   logic [NP-1:0] lo_req = '0;
   logic          aux_req = 1'b0;
   logic          ilock_en = 1'b0;
   logic          uvlo = 1'b0;
   logic          oc_trip = 1'b0;
   logic          ot_trip = 1'b0;
   logic          flt_clr = 1'b0;
   logic [NP-1:0] hi_gate;
   logic [NP-1:0] lo_gate;
   logic          aux_gate;
   logic [1:0]    flt_local;
   logic          err_n;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gdrv_ctrl #(.NUM_PAIRS(NP), .SYNC_STAGES(SYNC)) dut (
      .clk(clk), .rst_n(rst_n), .hi_req(hi_req), .lo_req(lo_req),
      .aux_req(aux_req), .ilock_en(ilock_en), .uvlo(uvlo),
      .oc_trip(oc_trip), .ot_trip(ot_trip), .flt_clr(flt_clr),
      .hi_gate(hi_gate), .lo_gate(lo_gate), .aux_gate(aux_gate),
      .flt_local(flt_local), .err_n(err_n)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic settle();
      repeat (LAT + 1) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic pulse_clr();
      @(negedge clk);
      flt_clr = 1'b1;
      @(negedge clk);
      flt_clr = 1'b0;
   endtask

   task automatic t_reset();
      check("R12 hi_gate in reset", hi_gate, 0);
      check("R12 flags in reset", flt_local, 0);
      check("R12 err_n in reset", err_n, 1);
      @(negedge clk);
      rst_n = 1'b1;
      settle();
      check("R12 gates after reset", {hi_gate, lo_gate, aux_gate}, 0);
      check("R12 err_n after reset", err_n, 1);
   endtask

   task automatic t_latency();
      @(negedge clk);
      ilock_en = 1'b0;
      hi_req = 3'b101;
      lo_req = 3'b010;
      @(posedge clk); @(posedge clk); @(negedge clk);
      check("R1 output unchanged before latency", hi_gate, 0);
      @(posedge clk); @(negedge clk);
      check("R1 upper gates at latency", hi_gate, 3'b101);
      check("R1 lower gates at latency", lo_gate, 3'b010);
   endtask

   task automatic t_no_guard();
      @(negedge clk);
      ilock_en = 1'b0;
      hi_req = 3'b111;
      lo_req = 3'b011;
      settle();
      check("R4 upper gates unguarded", hi_gate, 3'b111);
      check("R4 lower gates unguarded", lo_gate, 3'b011);
   endtask

   task automatic t_guard();
      @(negedge clk);
      ilock_en = 1'b1;
      hi_req = 3'b111;
      lo_req = 3'b011;
      settle();
      check("R2 lower wins, upper gates", hi_gate, 3'b100);
      check("R2 lower wins, lower gates", lo_gate, 3'b011);
      check("R3 no leg fully on", hi_gate & lo_gate, 0);
      @(negedge clk);
      lo_req = 3'b000;
      settle();
      check("R2 upper on when lower idle", hi_gate, 3'b111);
   endtask

   task automatic t_aux();
      @(negedge clk);
      aux_req = 1'b1;
      ilock_en = 1'b1;
      hi_req = 3'b000;
      lo_req = 3'b111;
      settle();
      check("R5 aux on with guard and legs", aux_gate, 1);
      @(negedge clk);
      ilock_en = 1'b0;
      lo_req = 3'b000;
      aux_req = 1'b0;
      settle();
      check("R5 aux off follows request", aux_gate, 0);
      @(negedge clk);
      aux_req = 1'b1;
      settle();
      check("R5 aux on unguarded", aux_gate, 1);
   endtask

   task automatic t_uvlo();
      @(negedge clk);
      hi_req = 3'b010;
      lo_req = 3'b001;
      ilock_en = 1'b1;
      uvlo = 1'b1;
      settle();
      check("R6 gates off in lockout", {hi_gate, lo_gate, aux_gate}, 0);
      check("R7 lockout sets no flag", flt_local, 0);
      check("R7 lockout keeps err_n high", err_n, 1);
      @(negedge clk);
      uvlo = 1'b0;
      settle();
      check("R6 gates resume after lockout", {hi_gate, lo_gate, aux_gate}, {3'b010, 3'b001, 1'b1});
   endtask

   task automatic t_overcurrent();
      @(negedge clk);
      oc_trip = 1'b1;
      settle();
      check("R8 over-current flag", flt_local, 2'b01);
      check("R8 err_n low", err_n, 0);
      check("R8 gates off on fault", {hi_gate, lo_gate, aux_gate}, 0);
      @(negedge clk);
      oc_trip = 1'b0;
      settle();
      check("R9 flag held after input drops", flt_local, 2'b01);
      check("R9 gates held off", {hi_gate, lo_gate, aux_gate}, 0);
      @(negedge clk);
      ot_trip = 1'b1;
      settle();
      check("R8 over-temperature flag", flt_local, 2'b11);
      pulse_clr();
      settle();
      check("R10 clear ignored while fault present", flt_local, 2'b11);
      check("R10 err_n still low", err_n, 0);
      @(negedge clk);
      ot_trip = 1'b0;
      settle();
      pulse_clr();
      settle();
      check("R9 flags released by clear", flt_local, 0);
      check("R9 err_n released", err_n, 1);
      check("R9 gates resume", {hi_gate, lo_gate, aux_gate}, {3'b010, 3'b001, 1'b1});
   endtask

   task automatic t_uv_keeps_fault();
      @(negedge clk);
      oc_trip = 1'b1;
      settle();
      @(negedge clk);
      uvlo = 1'b1;
      oc_trip = 1'b0;
      settle();
      @(negedge clk);
      uvlo = 1'b0;
      settle();
      check("R11 flag kept after lockout ends", flt_local, 2'b01);
      check("R11 gates off after lockout ends", {hi_gate, lo_gate, aux_gate}, 0);
      pulse_clr();
      settle();
      check("R11 clear releases after lockout", err_n, 1);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      t_latency();
      t_no_guard();
      t_guard();
      t_aux();
      t_uvlo();
      t_overcurrent();
      t_uv_keeps_fault();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule